// File: doc/BRIEF.md
# SoC Memory Map Address Decoder

This block sits between a 32-bit processor memory bus and the targets of a small system-on-chip. The bus has a valid flag, an address, byte write strobes, write data, a ready return and read data. For each access the block picks one target from the top address bits: an internal scratchpad held inside the block, the read port of an external serial flash, three single-word registers owned by the flash and UART engines, a 32-bit GPIO word held inside the block, or an unmapped hole. It then returns that target's ready and read data to the processor.

The scratchpad window covers the lowest 16 MB. Only the first `SRAM_WORDS` words of it exist. A read above the physical end is passed to the serial flash with the unchanged bus address. A write there is dropped. The targets held inside the block answer one cycle after the request. The targets outside it answer whenever they raise their ready line, and that ready and data pass through without a register. The processor must hold valid and the address steady until it sees ready, and then drop valid for at least one cycle.

Top module: `soc_addr_decoder`

## Requirements
- R1: While reset is active and after it is released with no access pending, `bus_ready` is 0, `gpio_out` is 0 and all four target selects are 0.
- R2: A scratchpad access (address bits 31:24 equal to 0 and address below `SRAM_WORDS*4`) raises `bus_ready` in the clock cycle after `bus_valid` appears, for exactly one cycle. A read returns the stored word.
- R3: In a scratchpad write, strobe bit n updates only bits 8n+7:8n of the addressed word.
- R4: A read with bits 31:24 equal to 0 and an address at or above `SRAM_WORDS*4` raises `flash_sel` with `tgt_addr` equal to the bus address. `bus_ready` and `bus_rdata` then follow `flash_ready` and `flash_rdata` in the same cycle.
- R5: A read with address bits 31:24 equal to 0x01 raises `flash_sel`. Its response passes through as in R4.
- R6: A write (any strobe set) to the flash window, or above the physical scratchpad, never raises `flash_sel`. It is acknowledged one cycle later and changes no stored word.
- R7: Word addresses 0x02000000, 0x02000004 and 0x02000008 raise `fcfg_sel`, `udiv_sel` and `udat_sel` respectively. Address bits 1:0 are ignored. Ready and read data pass through combinationally.
- R8: Word address 0x03000000 holds the GPIO word, which drives `gpio_out`. Writes honour the byte strobes as in R3, the access completes one cycle later, and a read returns the word.
- R9: Any other address in 0x02000000–0xFFFFFFFF raises no select. It completes one cycle after valid, with read data 0.
- R10: At most one select or internal acknowledge is active at a time, and `bus_rdata` is 0 whenever `bus_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, held until ready |
| bus_addr | input | 32 | Byte address |
| bus_wstrb | input | 4 | Byte write strobes; all zero means read |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access complete |
| bus_rdata | output | 32 | Read data, zero when not ready |
| tgt_addr | output | 32 | Address forwarded to external targets |
| tgt_wstrb | output | 4 | Strobes forwarded to external targets |
| tgt_wdata | output | 32 | Write data forwarded to external targets |
| flash_sel | output | 1 | Serial flash read request |
| flash_ready | input | 1 | Serial flash response valid |
| flash_rdata | input | 32 | Serial flash read data |
| fcfg_sel | output | 1 | Flash configuration register select |
| fcfg_ready | input | 1 | Configuration register ready |
| fcfg_rdata | input | 32 | Configuration register read data |
| udiv_sel | output | 1 | UART divider register select |
| udiv_ready | input | 1 | Divider register ready |
| udiv_rdata | input | 32 | Divider register read data |
| udat_sel | output | 1 | UART data register select |
| udat_ready | input | 1 | Data register ready |
| udat_rdata | input | 32 | Data register read data |
| gpio_out | output | 32 | GPIO word |

## Verification
The internal targets (scratchpad, GPIO, dropped writes, holes) answer through one register. The bench therefore drives the request just after a falling edge. It checks that ready is still low before the next rising edge, and then checks ready and data at the falling edge that follows. The external targets are combinational paths. For these, the bench checks selects, `tgt_addr`, ready and data one time unit after it drives the request, in the same cycle, and also with the target holding ready low. The effect of a dropped write is checked by reading the scratchpad word that an aliasing design would have overwritten.

// File: rtl/soc_dec_pkg.sv
package soc_dec_pkg;
  typedef enum logic [2:0] {
    TGT_HOLE,
    TGT_SRAM,
    TGT_FLASH,
    TGT_DROP,
    TGT_FCFG,
    TGT_UDIV,
    TGT_UDAT,
    TGT_GPIO
  } tgt_e;
endpackage

// File: rtl/soc_dec_region.sv
module soc_dec_region
  import soc_dec_pkg::*;
#(
  parameter int SRAM_WORDS = 256
) (
  input  logic [31:0] addr,
  input  logic        is_write,
  output tgt_e        tgt
);
  localparam logic [31:0] SRAM_LIMIT = 32'(SRAM_WORDS * 4);

  always_comb begin
    tgt = TGT_HOLE;
    unique case (addr[31:24])
      8'h00: begin
        if (addr < SRAM_LIMIT) tgt = TGT_SRAM;
        else                   tgt = is_write ? TGT_DROP : TGT_FLASH;
      end
      8'h01: tgt = is_write ? TGT_DROP : TGT_FLASH;
      8'h02: begin
        case (addr[23:2])
          22'd0:   tgt = TGT_FCFG;
          22'd1:   tgt = TGT_UDIV;
          22'd2:   tgt = TGT_UDAT;
          default: tgt = TGT_HOLE;
        endcase
      end
      8'h03: tgt = (addr[23:2] == 22'd0) ? TGT_GPIO : TGT_HOLE;
      default: tgt = TGT_HOLE;
    endcase
  end
endmodule

// File: rtl/soc_dec_sram.sv
module soc_dec_sram #(
  parameter int WORDS = 256,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] idx,
  input  logic [3:0]    wstrb,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wstrb[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/soc_dec_gpio.sv
module soc_dec_gpio (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wstrb,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  logic [31:0] q_d;

  always_comb begin
    q_d = q;
    for (int b = 0; b < 4; b++) begin
      if (wr_en && wstrb[b]) q_d[8*b +: 8] = wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_d;
  end

  assert_gpio_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(wr_en));
endmodule

// File: rtl/soc_addr_decoder.sv
module soc_addr_decoder
  import soc_dec_pkg::*;
#(
  parameter int SRAM_WORDS = 256,
  localparam int AW = $clog2(SRAM_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic [31:0] bus_addr,
  input  logic [3:0]  bus_wstrb,
  input  logic [31:0] bus_wdata,
  output logic        bus_ready,
  output logic [31:0] bus_rdata,
  output logic [31:0] tgt_addr,
  output logic [3:0]  tgt_wstrb,
  output logic [31:0] tgt_wdata,
  output logic        flash_sel,
  input  logic        flash_ready,
  input  logic [31:0] flash_rdata,
  output logic        fcfg_sel,
  input  logic        fcfg_ready,
  input  logic [31:0] fcfg_rdata,
  output logic        udiv_sel,
  input  logic        udiv_ready,
  input  logic [31:0] udiv_rdata,
  output logic        udat_sel,
  input  logic        udat_ready,
  input  logic [31:0] udat_rdata,
  output logic [31:0] gpio_out
);
  // reset: asynchronous assertion, release aligned to the clock
  logic [1:0] rst_sync;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  // decode
  tgt_e tgt;
  logic is_write;
  assign is_write = |bus_wstrb;

  soc_dec_region #(.SRAM_WORDS(SRAM_WORDS)) i_region (
    .addr(bus_addr), .is_write(is_write), .tgt(tgt)
  );

  // internal targets answer through one registered acknowledge
  logic        is_internal, launch, hole_launch;
  logic        ack_q, ack_d;
  logic [31:0] rdata_q, rdata_d;
  logic [31:0] sram_rdata;

  assign is_internal = (tgt == TGT_SRAM) || (tgt == TGT_DROP) ||
                       (tgt == TGT_GPIO) || (tgt == TGT_HOLE);
  assign launch      = bus_valid && is_internal && !ack_q;
  assign hole_launch = launch && (tgt == TGT_HOLE);

  soc_dec_sram #(.WORDS(SRAM_WORDS)) i_sram (
    .clk(clk),
    .wr_en(launch && (tgt == TGT_SRAM) && is_write),
    .idx(bus_addr[AW+1:2]),
    .wstrb(bus_wstrb),
    .wdata(bus_wdata),
    .rdata(sram_rdata)
  );

  soc_dec_gpio i_gpio (
    .clk(clk),
    .rst_n(rst_ok_n),
    .wr_en(launch && (tgt == TGT_GPIO) && is_write),
    .wstrb(bus_wstrb),
    .wdata(bus_wdata),
    .q(gpio_out)
  );

  always_comb begin
    ack_d   = launch;
    rdata_d = '0;
    if (!is_write) begin
      case (tgt)
        TGT_SRAM: rdata_d = sram_rdata;
        TGT_GPIO: rdata_d = gpio_out;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (launch) rdata_q <= rdata_d;
    end
  end

  // external targets
  assign tgt_addr  = bus_addr;
  assign tgt_wstrb = bus_wstrb;
  assign tgt_wdata = bus_wdata;
  assign flash_sel = bus_valid && (tgt == TGT_FLASH);
  assign fcfg_sel  = bus_valid && (tgt == TGT_FCFG);
  assign udiv_sel  = bus_valid && (tgt == TGT_UDIV);
  assign udat_sel  = bus_valid && (tgt == TGT_UDAT);

  // response mux
  always_comb begin
    bus_ready = 1'b0;
    bus_rdata = '0;
    if (ack_q) begin
      bus_ready = 1'b1;
      bus_rdata = rdata_q;
    end else if (flash_sel && flash_ready) begin
      bus_ready = 1'b1;
      bus_rdata = flash_rdata;
    end else if (fcfg_sel && fcfg_ready) begin
      bus_ready = 1'b1;
      bus_rdata = fcfg_rdata;
    end else if (udiv_sel && udiv_ready) begin
      bus_ready = 1'b1;
      bus_rdata = udiv_rdata;
    end else if (udat_sel && udat_ready) begin
      bus_ready = 1'b1;
      bus_rdata = udat_rdata;
    end
  end

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $onehot0({flash_sel, fcfg_sel, udiv_sel, udat_sel, ack_q}));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !bus_ready |-> (bus_rdata == '0));

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ack_q |=> !ack_q);

  assert_hole_zero_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    hole_launch |=> (bus_ready && bus_rdata == '0));

  assert_flash_no_write_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    flash_sel |-> (tgt_wstrb == 4'b0000));
endmodule

// File: tb/test_soc_addr_decoder.sv
module test_soc_addr_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic [3:0]  bus_wstrb;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [31:0] tgt_addr;
  logic [3:0]  tgt_wstrb;
  logic [31:0] tgt_wdata;
  logic        flash_sel, fcfg_sel, udiv_sel, udat_sel;
  logic        flash_ok;
  logic        flash_ready, fcfg_ready, udiv_ready, udat_ready;
  logic [31:0] flash_rdata, fcfg_rdata, udiv_rdata, udat_rdata;
  logic [31:0] gpio_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // external target models
  assign flash_ready = flash_ok;
  assign flash_rdata = 32'hF1A5_0000 ^ tgt_addr;
  assign fcfg_ready  = 1'b1;
  assign fcfg_rdata  = 32'hC0F6_0001;
  assign udiv_ready  = 1'b1;
  assign udiv_rdata  = 32'h0000_0068;
  assign udat_ready  = 1'b1;
  assign udat_rdata  = 32'hFFFF_FFFF;

  soc_addr_decoder i_soc_addr_decoder (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_wstrb(bus_wstrb),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .tgt_addr(tgt_addr), .tgt_wstrb(tgt_wstrb), .tgt_wdata(tgt_wdata),
    .flash_sel(flash_sel), .flash_ready(flash_ready), .flash_rdata(flash_rdata),
    .fcfg_sel(fcfg_sel), .fcfg_ready(fcfg_ready), .fcfg_rdata(fcfg_rdata),
    .udiv_sel(udiv_sel), .udiv_ready(udiv_ready), .udiv_rdata(udiv_rdata),
    .udat_sel(udat_sel), .udat_ready(udat_ready), .udat_rdata(udat_rdata),
    .gpio_out(gpio_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] sels();
    return {flash_sel, fcfg_sel, udiv_sel, udat_sel};
  endfunction

  // access answered by the block itself: ready due one cycle after valid
  task automatic int_access(input logic [31:0] addr, input logic [3:0] strb,
                            input logic [31:0] wdata, input string req,
                            output logic [31:0] rdata);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = addr; bus_wstrb = strb; bus_wdata = wdata;
    #1;
    check(bus_ready == 1'b0, req, 32'(bus_ready), 32'd0);
    check(sels() == 4'b0000, req, 32'(sels()), 32'd0);
    @(negedge clk);
    check(bus_ready == 1'b1, req, 32'(bus_ready), 32'd1);
    rdata = bus_rdata;
    bus_valid = 1'b0; bus_wstrb = '0;
    @(negedge clk);
    check(bus_ready == 1'b0, req, 32'(bus_ready), 32'd0);
  endtask

  // read answered by an external target: same-cycle pass-through
  task automatic ext_read(input logic [31:0] addr, input logic [3:0] exp_sel,
                          input logic [31:0] exp_data, input string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = addr; bus_wstrb = '0;
    #1;
    check(sels() == exp_sel, req, 32'(sels()), 32'(exp_sel));
    check(tgt_addr == addr, req, tgt_addr, addr);
    check(bus_ready == 1'b1, req, 32'(bus_ready), 32'd1);
    check(bus_rdata == exp_data, req, bus_rdata, exp_data);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bus_valid = 1'b0; bus_addr = '0; bus_wstrb = '0; bus_wdata = '0;
    flash_ok = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_ready == 1'b0, "R1", 32'(bus_ready), 32'd0);
    check(gpio_out == '0, "R1", gpio_out, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_ready == 1'b0 && sels() == 4'b0, "R1", 32'(sels()), 32'd0);
    check(gpio_out == '0, "R1", gpio_out, 32'd0);
  endtask

  task automatic t_sram;
    logic [31:0] r;
    int_access(32'h0000_0000, 4'hF, 32'h1122_3344, "R2", r);
    int_access(32'h0000_0000, 4'h0, '0, "R2", r);
    check(r == 32'h1122_3344, "R2", r, 32'h1122_3344);
    int_access(32'h0000_0004, 4'hF, 32'hAABB_CCDD, "R3", r);
    int_access(32'h0000_0004, 4'b0010, 32'h0000_EE00, "R3", r);
    int_access(32'h0000_0004, 4'h0, '0, "R3", r);
    check(r == 32'hAABB_EEDD, "R3", r, 32'hAABB_EEDD);
    int_access(32'h0000_03FC, 4'hF, 32'h5A5A_0FF0, "R2", r);
    int_access(32'h0000_03FC, 4'h0, '0, "R2", r);
    check(r == 32'h5A5A_0FF0, "R2", r, 32'h5A5A_0FF0);
  endtask

  task automatic t_fallthrough;
    ext_read(32'h0000_0400, 4'b1000, 32'hF1A5_0400, "R4");
    ext_read(32'h00FF_FFFC, 4'b1000, 32'hF1A5_0000 ^ 32'h00FF_FFFC, "R4");
  endtask

  task automatic t_flash;
    ext_read(32'h0100_0000, 4'b1000, 32'hF0A5_0000, "R5");
    ext_read(32'h01FF_FFFC, 4'b1000, 32'hF1A5_0000 ^ 32'h01FF_FFFC, "R5");
    @(negedge clk);
    flash_ok = 1'b0;
    bus_valid = 1'b1; bus_addr = 32'h0100_0040; bus_wstrb = '0;
    #1;
    check(flash_sel == 1'b1, "R10", 32'(flash_sel), 32'd1);
    check(bus_ready == 1'b0, "R10", 32'(bus_ready), 32'd0);
    check(bus_rdata == '0, "R10", bus_rdata, 32'd0);
    @(negedge clk);
    flash_ok = 1'b1;
    #1;
    check(bus_ready && bus_rdata == 32'hF0A5_0040, "R5", bus_rdata, 32'hF0A5_0040);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_drop;
    logic [31:0] r;
    int_access(32'h0000_0400, 4'hF, 32'hDEAD_BEEF, "R6", r);
    int_access(32'h0100_0010, 4'hF, 32'hDEAD_BEEF, "R6", r);
    int_access(32'h0000_0000, 4'h0, '0, "R6", r);
    check(r == 32'h1122_3344, "R6", r, 32'h1122_3344);
  endtask

  task automatic t_regs;
    ext_read(32'h0200_0000, 4'b0100, 32'hC0F6_0001, "R7");
    ext_read(32'h0200_0004, 4'b0010, 32'h0000_0068, "R7");
    ext_read(32'h0200_000B, 4'b0001, 32'hFFFF_FFFF, "R7");
  endtask

  task automatic t_gpio;
    logic [31:0] r;
    int_access(32'h0300_0000, 4'hF, 32'h1234_5678, "R8", r);
    check(gpio_out == 32'h1234_5678, "R8", gpio_out, 32'h1234_5678);
    int_access(32'h0300_0000, 4'b1000, 32'hFF00_0000, "R8", r);
    check(gpio_out == 32'hFF34_5678, "R8", gpio_out, 32'hFF34_5678);
    int_access(32'h0300_0000, 4'h0, '0, "R8", r);
    check(r == 32'hFF34_5678, "R8", r, 32'hFF34_5678);
  endtask

  task automatic t_hole;
    logic [31:0] r;
    int_access(32'h0200_000C, 4'h0, '0, "R9", r);
    check(r == '0, "R9", r, 32'd0);
    int_access(32'h0300_0004, 4'h0, '0, "R9", r);
    check(r == '0, "R9", r, 32'd0);
    int_access(32'h8000_0000, 4'h0, '0, "R9", r);
    check(r == '0, "R9", r, 32'd0);
    int_access(32'h0300_0004, 4'hF, 32'h0BAD_0BAD, "R9", r);
    check(gpio_out == 32'hFF34_5678, "R9", gpio_out, 32'hFF34_5678);
  endtask

  initial begin
    t_reset();
    t_sram();
    t_fallthrough();
    t_flash();
    t_drop();
    t_regs();
    t_gpio();
    t_hole();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule